// File: doc/BRIEF.md
# Video Line and Field Timing Generator

This block walks the raster of an interlaced analog television frame one output sample at a time. It keeps a pixel counter within the line and a line counter within the frame. From those two counters it derives a horizontal active flag, a vertical active flag, their combination, a field indicator and a chroma slot flag for 4:2:2 pixel pairs. The counters move only on cycles where the sample strobe is high, so the block can run from a system clock faster than the sample rate.

Four raster variants are selected by a two-bit standard input: two with 525 lines, two with 625 lines, and for each line count one square-pixel and one 601-style sampling. The vertical window is evaluated in half-line units, so that window edges falling in the middle of a line compare exactly. A new standard value is taken only when the frame wraps.

Top module: `vtg_timing_gen`

## Requirements
- R1: During reset and on the first cycle after it, pix_cnt, line_cnt, field_o, h_act_o, v_act_o, act_o and cr_slot_o are all zero, and the standard in use is the value on std_sel.
- R2: On a cycle with smp_vld low, none of the outputs changes.
- R3: On each smp_vld, pix_cnt increments. From total-1 it returns to 0 and line_cnt advances. The totals are std_sel encoding 0 = 525-line square pixel (TOT_525_SQ, 780), 1 = 525-line 601 (TOT_525_601, 858), 2 = 625-line 601 (TOT_625_601, 864) and 3 = 625-line square pixel (TOT_625_SQ, 944).
- R4: line_cnt is zero-based. It returns to 0 after line 524 in standards 0 and 1, and after line 624 in standards 2 and 3.
- R5: h_act_o is high when off <= pix_cnt < off + act, where off = (total - act)/2. The active widths are 640 for std 0, 720 for std 1 and std 2, and 768 for std 3.
- R6: Let the half-line index be hl = 2*line_cnt + (pix_cnt >= total/2). v_act_o is high for 42 <= hl < 525 or 569 <= hl < 1050 in 525-line standards, and for 45 <= hl < 620 or 670 <= hl < 1247 in 625-line standards.
- R7: field_o is 1 exactly when hl >= 525 (525-line) or hl >= 625 (625-line). It therefore changes in the middle of line 262 or line 312, and it returns to 0 when the frame wraps.
- R8: act_o is high exactly when h_act_o and v_act_o are both high.
- R9: cr_slot_o is high on active pixels at an odd distance (pix_cnt - off) from the window start, which marks the second pixel of each 4:2:2 pair. It is low outside the horizontal window.
- R10: A change on std_sel takes effect only on the sample that wraps the frame to line 0, pixel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe; the counters advance only when it is high |
| std_sel | input | 2 | Raster standard request, taken at the frame wrap |
| pix_cnt | output | PIX_W | Pixel index within the line, zero-based |
| line_cnt | output | LINE_W | Line index within the frame, zero-based |
| field_o | output | 1 | 0 for the first field, 1 for the second |
| h_act_o | output | 1 | Inside the horizontal active window |
| v_act_o | output | 1 | Inside the vertical active window |
| act_o | output | 1 | Visible picture sample |
| cr_slot_o | output | 1 | Second pixel of a 4:2:2 chroma pair |

## Verification
The bench builds the block with line totals of 8, 10, 12 and 14 samples and active widths of 4, 6, 6 and 8. The line counts stay at the full 525 and 625, so the real half-line window edges and field boundaries are kept. These short lines make complete frames of all four standards affordable, and every sample of each frame is compared with an arithmetic model. The std 2 setting has an odd start offset, which exercises the chroma pairing away from even pixel indices. The standard request is changed in the middle of a frame and the strobe is held low for long stretches, which exercises the frame-start latch and the hold behaviour.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        STD_525_SQ  = 2'd0,
        STD_525_601 = 2'd1,
        STD_625_601 = 2'd2,
        STD_625_SQ  = 2'd3
    } vtg_std_e;

    localparam int LINES_525 = 525;
    localparam int LINES_625 = 625;

endpackage

// File: rtl/vtg_std_table.sv
module vtg_std_table
    import vtg_pkg::*;
#(
    parameter int PIX_W       = 10,
    parameter int LINE_W      = 10,
    parameter int TOT_525_SQ  = 780,
    parameter int TOT_525_601 = 858,
    parameter int TOT_625_601 = 864,
    parameter int TOT_625_SQ  = 944,
    parameter int ACT_525_SQ  = 640,
    parameter int ACT_601     = 720,
    parameter int ACT_625_SQ  = 768
) (
    input  vtg_std_e          std_i,
    output logic [PIX_W-1:0]  tot_m1_o,
    output logic [PIX_W-1:0]  half_o,
    output logic [PIX_W-1:0]  hoff_o,
    output logic [PIX_W-1:0]  hend_o,
    output logic [LINE_W-1:0] last_line_o,
    output logic              is625_o
);
    // centred horizontal window start per standard
    localparam int OFF0 = (TOT_525_SQ  - ACT_525_SQ) / 2;
    localparam int OFF1 = (TOT_525_601 - ACT_601)    / 2;
    localparam int OFF2 = (TOT_625_601 - ACT_601)    / 2;
    localparam int OFF3 = (TOT_625_SQ  - ACT_625_SQ) / 2;

    always_comb begin
        tot_m1_o    = PIX_W'(TOT_525_SQ - 1);
        half_o      = PIX_W'(TOT_525_SQ / 2);
        hoff_o      = PIX_W'(OFF0);
        hend_o      = PIX_W'(OFF0 + ACT_525_SQ);
        last_line_o = LINE_W'(LINES_525 - 1);
        is625_o     = 1'b0;
        case (std_i)
            STD_525_SQ: ;
            STD_525_601: begin
                tot_m1_o = PIX_W'(TOT_525_601 - 1);
                half_o   = PIX_W'(TOT_525_601 / 2);
                hoff_o   = PIX_W'(OFF1);
                hend_o   = PIX_W'(OFF1 + ACT_601);
            end
            STD_625_601: begin
                tot_m1_o    = PIX_W'(TOT_625_601 - 1);
                half_o      = PIX_W'(TOT_625_601 / 2);
                hoff_o      = PIX_W'(OFF2);
                hend_o      = PIX_W'(OFF2 + ACT_601);
                last_line_o = LINE_W'(LINES_625 - 1);
                is625_o     = 1'b1;
            end
            STD_625_SQ: begin
                tot_m1_o    = PIX_W'(TOT_625_SQ - 1);
                half_o      = PIX_W'(TOT_625_SQ / 2);
                hoff_o      = PIX_W'(OFF3);
                hend_o      = PIX_W'(OFF3 + ACT_625_SQ);
                last_line_o = LINE_W'(LINES_625 - 1);
                is625_o     = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vtg_vwindow.sv
module vtg_vwindow
    import vtg_pkg::*;
#(
    parameter int HL_W = 11
) (
    input  logic [HL_W-1:0] hl_i,
    input  logic            is625_i,
    output logic            v_act_o,
    output logic [HL_W-1:0] fld_hl_o
);
    // window edges in half-line units, one pair per field
    localparam int W525_S [2] = '{42, 569};
    localparam int W525_E [2] = '{525, 1050};
    localparam int W625_S [2] = '{45, 670};
    localparam int W625_E [2] = '{620, 1247};

    logic [1:0] in_win;

    for (genvar g = 0; g < 2; g++) begin : g_win
        logic in525, in625;
        assign in525 = (hl_i >= HL_W'(W525_S[g])) && (hl_i < HL_W'(W525_E[g]));
        assign in625 = (hl_i >= HL_W'(W625_S[g])) && (hl_i < HL_W'(W625_E[g]));
        assign in_win[g] = is625_i ? in625 : in525;
    end

    assign v_act_o  = |in_win;
    assign fld_hl_o = is625_i ? HL_W'(LINES_625) : HL_W'(LINES_525);

endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
    import vtg_pkg::*;
#(
    parameter int PIX_W       = 10,
    parameter int LINE_W      = 10,
    parameter int TOT_525_SQ  = 780,
    parameter int TOT_525_601 = 858,
    parameter int TOT_625_601 = 864,
    parameter int TOT_625_SQ  = 944,
    parameter int ACT_525_SQ  = 640,
    parameter int ACT_601     = 720,
    parameter int ACT_625_SQ  = 768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [1:0]        std_sel,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt,
    output logic              field_o,
    output logic              h_act_o,
    output logic              v_act_o,
    output logic              act_o,
    output logic              cr_slot_o
);
    localparam int HL_W = LINE_W + 1;

    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [LINE_W-1:0] line;
        vtg_std_e          std;
        logic              field;
        logic              h_act;
        logic              v_act;
        logic              act;
        logic              cr;
    } vtg_state_t;

    vtg_state_t state_d, state_q;

    // table for the standard now running
    logic [PIX_W-1:0]  tot_m1_c, half_c, hoff_c, hend_c;
    logic [LINE_W-1:0] last_c;
    logic              is625_c;
    // table for the standard of the next sample
    logic [PIX_W-1:0]  tot_m1_n, half_n, hoff_n, hend_n;
    logic [LINE_W-1:0] last_n;
    logic              is625_n;

    logic [PIX_W-1:0]  pix_n;
    logic [LINE_W-1:0] line_n;
    vtg_std_e          std_n;
    logic              frame_wrap;
    logic [HL_W-1:0]   hl_c, hl_n, fld_hl_n;
    logic              v_act_n;
    logic [PIX_W-1:0]  rel_n;
    logic [1:0]        std_cur;

    assign std_cur = state_q.std;

    vtg_std_table #(
        .PIX_W(PIX_W), .LINE_W(LINE_W),
        .TOT_525_SQ(TOT_525_SQ), .TOT_525_601(TOT_525_601),
        .TOT_625_601(TOT_625_601), .TOT_625_SQ(TOT_625_SQ),
        .ACT_525_SQ(ACT_525_SQ), .ACT_601(ACT_601), .ACT_625_SQ(ACT_625_SQ)
    ) u_tbl_cur (
        .std_i(state_q.std), .tot_m1_o(tot_m1_c), .half_o(half_c),
        .hoff_o(hoff_c), .hend_o(hend_c), .last_line_o(last_c), .is625_o(is625_c)
    );

    vtg_std_table #(
        .PIX_W(PIX_W), .LINE_W(LINE_W),
        .TOT_525_SQ(TOT_525_SQ), .TOT_525_601(TOT_525_601),
        .TOT_625_601(TOT_625_601), .TOT_625_SQ(TOT_625_SQ),
        .ACT_525_SQ(ACT_525_SQ), .ACT_601(ACT_601), .ACT_625_SQ(ACT_625_SQ)
    ) u_tbl_nxt (
        .std_i(std_n), .tot_m1_o(tot_m1_n), .half_o(half_n),
        .hoff_o(hoff_n), .hend_o(hend_n), .last_line_o(last_n), .is625_o(is625_n)
    );

    // counter advance
    always_comb begin
        pix_n      = state_q.pix;
        line_n     = state_q.line;
        std_n      = state_q.std;
        frame_wrap = 1'b0;
        if (smp_vld) begin
            if (state_q.pix == tot_m1_c) begin
                pix_n = '0;
                if (state_q.line == last_c) begin
                    line_n     = '0;
                    std_n      = vtg_std_e'(std_sel);
                    frame_wrap = 1'b1;
                end else begin
                    line_n = state_q.line + 1'b1;
                end
            end else begin
                pix_n = state_q.pix + 1'b1;
            end
        end
    end

    assign hl_c = {state_q.line, 1'b0} + HL_W'(state_q.pix >= half_c);
    assign hl_n = {line_n, 1'b0} + HL_W'(pix_n >= half_n);

    vtg_vwindow #(.HL_W(HL_W)) u_vwin (
        .hl_i(hl_n), .is625_i(is625_n), .v_act_o(v_act_n), .fld_hl_o(fld_hl_n)
    );

    assign rel_n = pix_n - hoff_n;

    always_comb begin
        state_d       = state_q;
        state_d.pix   = pix_n;
        state_d.line  = line_n;
        state_d.std   = std_n;
        state_d.h_act = (pix_n >= hoff_n) && (pix_n < hend_n);
        state_d.v_act = v_act_n;
        state_d.act   = state_d.h_act && v_act_n;
        state_d.cr    = state_d.h_act && rel_n[0];
        if (frame_wrap || ((hl_n != hl_c) && (hl_n == fld_hl_n))) begin
            state_d.field = ~state_q.field;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.std   <= vtg_std_e'(std_sel);
        end else begin
            state_q <= state_d;
        end
    end

    assign pix_cnt   = state_q.pix;
    assign line_cnt  = state_q.line;
    assign field_o   = state_q.field;
    assign h_act_o   = state_q.h_act;
    assign v_act_o   = state_q.v_act;
    assign act_o     = state_q.act;
    assign cr_slot_o = state_q.cr;

endmodule

// File: rtl/vtg_timing_chk.sv
module vtg_timing_chk #(
    parameter int PIX_W  = 10,
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic [PIX_W-1:0]  pix_cnt,
    input logic [LINE_W-1:0] line_cnt,
    input logic              field_o,
    input logic              h_act_o,
    input logic              v_act_o,
    input logic              act_o,
    input logic              cr_slot_o,
    input logic [1:0]        std_cur
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(pix_cnt) && $stable(line_cnt) && $stable(field_o) && $stable(act_o));

    p_pix_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> (pix_cnt == ($past(pix_cnt) + 1'b1)) || (pix_cnt == '0));

    p_line_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> (line_cnt == $past(line_cnt)) ||
                    ((pix_cnt == '0) && ((line_cnt == ($past(line_cnt) + 1'b1)) || (line_cnt == '0))));

    p_field_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(field_o) |-> !v_act_o);

    p_act_and_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |-> h_act_o && v_act_o);

    p_cr_in_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cr_slot_o |-> h_act_o);

    p_std_at_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(std_cur) |-> (pix_cnt == '0) && (line_cnt == '0));

endmodule

bind vtg_timing_gen vtg_timing_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .pix_cnt(pix_cnt),
    .line_cnt(line_cnt), .field_o(field_o), .h_act_o(h_act_o),
    .v_act_o(v_act_o), .act_o(act_o), .cr_slot_o(cr_slot_o), .std_cur(std_cur)
);

// File: tb/vtg_timing_gen_tb.sv
module vtg_timing_gen_tb;
    localparam int PIX_W  = 4;
    localparam int LINE_W = 10;
    localparam int TOT [4] = '{8, 10, 12, 14};
    localparam int ACT [4] = '{4, 6, 6, 8};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_vld = 1'b0;
    logic [1:0]        std_sel = 2'd0;
    logic [PIX_W-1:0]  pix_cnt;
    logic [LINE_W-1:0] line_cnt;
    logic              field_o, h_act_o, v_act_o, act_o, cr_slot_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_pix = 0, m_line = 0, m_std = 0, m_frames = 0;
    bit last_vld = 1'b0;

    always #2 clk = ~clk;

    vtg_timing_gen #(
        .PIX_W(PIX_W), .LINE_W(LINE_W),
        .TOT_525_SQ(8), .TOT_525_601(10), .TOT_625_601(12), .TOT_625_SQ(14),
        .ACT_525_SQ(4), .ACT_601(6), .ACT_625_SQ(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .std_sel(std_sel),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field_o(field_o),
        .h_act_o(h_act_o), .v_act_o(v_act_o), .act_o(act_o), .cr_slot_o(cr_slot_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s at line %0d pix %0d std %0d: got %0d expected %0d",
                     tag, m_line, m_pix, m_std, got, exp);
        end
    endtask

    task automatic check_all();
        int tot, off, lines, hl, e_h, e_v, e_f, e_cr;
        tot   = TOT[m_std];
        off   = (tot - ACT[m_std]) / 2;
        lines = (m_std < 2) ? 525 : 625;
        hl    = 2 * m_line + ((m_pix >= tot / 2) ? 1 : 0);
        e_h   = (m_pix >= off && m_pix < off + ACT[m_std]) ? 1 : 0;
        if (lines == 525)
            e_v = ((hl >= 42 && hl < 525) || (hl >= 569 && hl < 1050)) ? 1 : 0;
        else
            e_v = ((hl >= 45 && hl < 620) || (hl >= 670 && hl < 1247)) ? 1 : 0;
        e_f  = (hl >= lines) ? 1 : 0;
        e_cr = (e_h == 1 && ((m_pix - off) % 2) == 1) ? 1 : 0;
        chk(last_vld ? "R3 pix" : "R2 pix hold", int'(pix_cnt), m_pix);
        chk(last_vld ? "R4 line" : "R2 line hold", int'(line_cnt), m_line);
        chk((m_line == 0) ? "R10 h_act" : "R5 h_act", int'(h_act_o), e_h);
        chk("R6 v_act", int'(v_act_o), e_v);
        chk("R7 field", int'(field_o), e_f);
        chk("R8 act", int'(act_o), e_h & e_v);
        chk("R9 cr_slot", int'(cr_slot_o), e_cr);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        int seq [4] = '{2, 1, 3, 0};
        int step = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pix", int'(pix_cnt), 0);
        chk("R1 line", int'(line_cnt), 0);
        chk("R1 flags", int'({field_o, h_act_o, v_act_o, act_o, cr_slot_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pix after", int'(pix_cnt), 0);
        chk("R1 flags after", int'({field_o, h_act_o, v_act_o, act_o, cr_slot_o}), 0);
        while (m_frames < 5) begin
            check_all();
            smp_vld = ((step % 4) != 3) && !(step >= 2000 && step < 2060);
            // request the next standard mid-frame (R10)
            if (m_line == 100) std_sel = 2'(seq[m_frames % 4]);
            @(posedge clk);
            last_vld = smp_vld;
            if (smp_vld) begin
                if (m_pix == TOT[m_std] - 1) begin
                    m_pix = 0;
                    if (m_line == ((m_std < 2) ? 524 : 624)) begin
                        m_line = 0;
                        m_std = int'(std_sel);
                        m_frames++;
                    end else begin
                        m_line++;
                    end
                end else begin
                    m_pix++;
                end
            end
            @(negedge clk);
            step++;
        end
        check_all();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule